// File: doc/BRIEF.md
# Reference Voltage Soft-Start Ramp Controller

This block drives the digital code of an external DAC that sets the reference of a secondary supply. It moves that code toward a target code in steps of a fixed size, paced by a free-running microsecond tick. The code is in 8 mV units at default parameters. A two-bit step-mode input selects one of three behaviours. The target can be loaded directly, stepped at a fast rate, or stepped at a slow rate.

A one-cycle start pulse begins a soft start. During a soft start the code always ramps at the fast rate, whatever the step mode says, until it reaches the target. After that the selected step mode governs again. An active-low supply enable falls once the code represents more than 300 mV. A disable input forces the code to zero and holds the enable high. This disable is used while the processor runs in parallel-VID mode. A read-back port gives the current code converted to millivolts.

Top module: `ref_ramp_ctl`

## Requirements
- R1: With step_mode = 0 and no soft start in progress, dac_code equals target_code one clock cycle after target_code is applied.
- R2: With step_mode = 1, dac_code changes only on us_tick pulses, once every FAST_US ticks, and each change is STEP_LSB codes. At defaults one code is 8 mV. With no tick pulses, dac_code holds.
- R3: With step_mode = 2, dac_code steps once every SLOW_US ticks. This is the default rate. Code 3 behaves exactly as code 2.
- R4: A soft_start pulse makes the code ramp at the fast rate until it equals the target, whatever step_mode is, including mode 0. After that, step_mode governs again.
- R5: supply_en_n is 0 exactly when dac_code × LSB_MV exceeds THRESH_MV. At defaults this means 0 for codes 38 and above, and 1 for codes 37 and below.
- R6: While ref_off is 1, dac_code is 0 from the next cycle on and supply_en_n is 1. Changes of target_code and soft_start pulses are ignored while ref_off is 1.
- R7: readback_mv equals dac_code × LSB_MV, with LSB_MV = 8 at defaults.
- R8: When the distance to the target is smaller than STEP_LSB, the last step is shortened so that dac_code lands exactly on the target and never passes it.
- R9: A target change during a ramp continues from the present code, in the direction of the new target. The next step comes one full period after the previous step, because the pacing is not restarted.
- R10: During reset and after it, dac_code is 0, supply_en_n is 1 and readback_mv is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| target_code | input | CODE_W | Target DAC code |
| step_mode | input | 2 | 0 direct load, 1 fast ramp, 2 or 3 slow ramp |
| ref_off | input | 1 | Forces the code to zero and turns off the enable |
| soft_start | input | 1 | One-cycle pulse that starts a fast-rate soft start |
| us_tick | input | 1 | One-cycle pulse every microsecond |
| dac_code | output | CODE_W | Code driven to the external DAC |
| supply_en_n | output | 1 | Active-low enable for the secondary supply |
| readback_mv | output | CODE_W+$clog2(LSB_MV) | Current code in millivolts |

## Verification
The in-module assertions check four properties on every cycle: the zero forcing under ref_off, the one-cycle direct load, a held code between pacing events, and the bound on each step that keeps the ramp from overshooting. The bench scenarios cover what depends on history. This includes the spacing between steps for each rate, the soft start overriding mode 0, and the unbroken pacing across a target change. A second instance with a three-code stride exercises the shortened last step. A sweep of every target code in direct mode checks the enable threshold and the read-back.

// File: rtl/ref_ramp_pkg.sv
package ref_ramp_pkg;

  typedef enum logic [1:0] {
    MODE_DIRECT = 2'd0,
    MODE_FAST   = 2'd1,
    MODE_SLOW   = 2'd2,
    MODE_SLOW_B = 2'd3
  } step_mode_e;

  // One step from cur toward tgt, never passing tgt.
  function automatic int step_toward(int cur, int tgt, int stride);
    if (cur < tgt) return (tgt - cur > stride) ? cur + stride : tgt;
    if (cur > tgt) return (cur - tgt > stride) ? cur - stride : tgt;
    return cur;
  endfunction

  // Lowest code whose voltage is strictly above mv.
  function automatic int first_code_above(int mv, int lsb_mv);
    return mv / lsb_mv + 1;
  endfunction

endpackage

// File: rtl/ref_ramp_pacer.sv
module ref_ramp_pacer #(
  parameter int FAST_US = 100,
  parameter int SLOW_US = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic moving,
  input  logic use_fast,
  input  logic us_tick,
  output logic step_fire
);
  localparam int MAX_US = (FAST_US > SLOW_US) ? FAST_US : SLOW_US;
  localparam int CNT_W  = $clog2(MAX_US + 1);

  logic [CNT_W-1:0] tick_cnt;
  logic [CNT_W-1:0] limit;

  assign limit     = use_fast ? CNT_W'(FAST_US - 1) : CNT_W'(SLOW_US - 1);
  assign step_fire = moving && us_tick && (tick_cnt >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         tick_cnt <= '0;
    else if (!moving)   tick_cnt <= '0;
    else if (step_fire) tick_cnt <= '0;
    else if (us_tick)   tick_cnt <= tick_cnt + 1'b1;
  end

  a_r2_fire_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    step_fire |-> (us_tick && moving));

endmodule

// File: rtl/ref_ramp_ctl.sv
module ref_ramp_ctl
  import ref_ramp_pkg::*;
#(
  parameter int CODE_W    = 8,
  parameter int LSB_MV    = 8,
  parameter int STEP_LSB  = 1,
  parameter int THRESH_MV = 300,
  parameter int FAST_US   = 100,
  parameter int SLOW_US   = 200
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [CODE_W-1:0]                 target_code,
  input  logic [1:0]                        step_mode,
  input  logic                              ref_off,
  input  logic                              soft_start,
  input  logic                              us_tick,
  output logic [CODE_W-1:0]                 dac_code,
  output logic                              supply_en_n,
  output logic [CODE_W+$clog2(LSB_MV)-1:0]  readback_mv
);
  localparam int RB_W     = CODE_W + $clog2(LSB_MV);
  localparam int THR_CODE = first_code_above(THRESH_MV, LSB_MV);

  step_mode_e  mode;
  logic [CODE_W-1:0] code_q;
  logic        soft_q;
  logic        direct_load;
  logic        moving;
  logic        use_fast;
  logic        step_fire;
  logic [CODE_W-1:0] step_next;

  assign mode        = step_mode_e'(step_mode);
  assign direct_load = !ref_off && !soft_q && !soft_start && (mode == MODE_DIRECT);
  assign moving      = !ref_off && !direct_load && (code_q != target_code);
  assign use_fast    = soft_q || (mode == MODE_FAST);
  assign step_next   = CODE_W'(step_toward(int'(code_q), int'(target_code), STEP_LSB));

  ref_ramp_pacer #(
    .FAST_US (FAST_US),
    .SLOW_US (SLOW_US)
  ) u_pacer (
    .clk       (clk),
    .rst_n     (rst_n),
    .moving    (moving),
    .use_fast  (use_fast),
    .us_tick   (us_tick),
    .step_fire (step_fire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           soft_q <= 1'b0;
    else if (ref_off)     soft_q <= 1'b0;
    else if (soft_start)  soft_q <= 1'b1;
    else if (code_q == target_code) soft_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           code_q <= '0;
    else if (ref_off)     code_q <= '0;
    else if (direct_load) code_q <= target_code;
    else if (step_fire)   code_q <= step_next;
  end

  assign dac_code    = code_q;
  assign supply_en_n = (int'(code_q) < THR_CODE);
  assign readback_mv = RB_W'(code_q) * RB_W'(LSB_MV);

  a_r6_off_forces_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ref_off |=> (dac_code == '0) && supply_en_n);

  a_r1_direct_load: assert property (@(posedge clk) disable iff (!rst_n)
    direct_load |=> (dac_code == $past(target_code)));

  a_r2_hold_between_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_fire && !ref_off && !direct_load) |=> $stable(dac_code));

  a_r8_no_overshoot_up: assert property (@(posedge clk) disable iff (!rst_n)
    (step_fire && (code_q < target_code)) |=> (dac_code <= $past(target_code)));

  a_r8_no_overshoot_down: assert property (@(posedge clk) disable iff (!rst_n)
    (step_fire && (code_q > target_code)) |=> (dac_code >= $past(target_code)));

endmodule

// File: tb/ref_ramp_ctl_bench.sv
module ref_ramp_ctl_bench;
  localparam int FAST = 3;
  localparam int SLOW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] tgt = 8'd0;
  logic [1:0] mode = 2'd0;
  logic off = 1'b0;
  logic start = 1'b0;
  logic tick = 1'b1;
  wire [7:0]  code_a, code_b;
  wire        en_a, en_b;
  wire [10:0] rb_a, rb_b;
  int n_cmp = 0;
  int n_bad = 0;
  int cyc_cnt = 0;

  always #4 clk = ~clk;

  ref_ramp_ctl #(.FAST_US(FAST), .SLOW_US(SLOW), .STEP_LSB(1)) u_ref_ramp_ctl (
    .clk(clk), .rst_n(rst_n), .target_code(tgt), .step_mode(mode), .ref_off(off),
    .soft_start(start), .us_tick(tick), .dac_code(code_a), .supply_en_n(en_a),
    .readback_mv(rb_a));

  ref_ramp_ctl #(.FAST_US(FAST), .SLOW_US(SLOW), .STEP_LSB(3)) u_ref_ramp_ctl_wide (
    .clk(clk), .rst_n(rst_n), .target_code(tgt), .step_mode(mode), .ref_off(off),
    .soft_start(start), .us_tick(tick), .dac_code(code_b), .supply_en_n(en_b),
    .readback_mv(rb_b));

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 150000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc_cnt);
      summary();
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int code_of(int i); return (i == 0) ? int'(code_a) : int'(code_b); endfunction
  function automatic int en_of(int i);   return (i == 0) ? int'(en_a)   : int'(en_b);   endfunction
  function automatic int rb_of(int i);   return (i == 0) ? int'(rb_a)   : int'(rb_b);   endfunction

  // Follows both instances to goal; checks stride, spacing, direction, read-back, enable.
  task automatic watch_ramp(input string req, input int goal, input int per);
    int last[2];
    int since[2];
    int nchg[2];
    int stp[2];
    stp[0] = 1; stp[1] = 3;
    for (int i = 0; i < 2; i++) begin last[i] = code_of(i); since[i] = 0; nchg[i] = 0; end
    for (int cyc = 0; cyc < 300 * per + 20; cyc++) begin
      @(negedge clk);
      for (int i = 0; i < 2; i++) begin
        int c;
        c = code_of(i);
        since[i]++;
        if (c != last[i]) begin
          int rem;
          int d;
          rem = (goal > last[i]) ? goal - last[i] : last[i] - goal;
          d   = (c > last[i]) ? c - last[i] : last[i] - c;
          chk({req, " step size / R8 landing"}, d, (rem < stp[i]) ? rem : stp[i]);
          chk({req, " direction"}, (c > last[i]) ? 1 : 0, (goal > last[i]) ? 1 : 0);
          if (nchg[i] > 0) chk({req, " step period"}, since[i], per);
          chk("R7 readback", rb_of(i), c * 8);
          chk("R5 enable threshold", en_of(i), (c >= 38) ? 0 : 1);
          last[i] = c; since[i] = 0; nchg[i]++;
        end
      end
      if (code_of(0) == goal && code_of(1) == goal) break;
    end
    chk({req, " final code narrow"}, code_of(0), goal);
    chk({req, " final code wide"}, code_of(1), goal);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    int v;
    int n;
    repeat (3) @(negedge clk);
    chk("R10 reset code", code_a, 0);
    chk("R10 reset enable", en_a, 1);
    chk("R10 reset readback", rb_a, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 code after reset", code_b, 0);

    // R4: soft start overrides direct mode, fast rate
    tgt = 8'd50; mode = 2'd0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    watch_ramp("R4 soft start", 50, FAST);

    // R1: direct-load sweep of every code
    for (int t = 0; t < 256; t++) begin
      tgt = 8'(t);
      @(negedge clk);
      chk("R1 direct load", code_a, t);
      chk("R1 direct load wide", code_b, t);
      chk("R7 readback sweep", rb_a, t * 8);
      chk("R5 enable sweep", en_a, (t >= 38) ? 0 : 1);
    end
    repeat (2) @(negedge clk);

    mode = 2'd2; tgt = 8'd22;
    watch_ramp("R3 slow down", 22, SLOW);
    mode = 2'd1; tgt = 8'd60;
    watch_ramp("R2 fast up", 60, FAST);
    mode = 2'd3; tgt = 8'd90;
    watch_ramp("R3 mode3 slow", 90, SLOW);

    // R9: redirect mid-ramp
    mode = 2'd2; tgt = 8'd40;
    v = code_a;
    n = 0;
    while (code_a == 8'(v) && n < 50) begin @(negedge clk); n++; end
    v = code_a;
    tgt = 8'd230;
    n = 0;
    while (code_a == 8'(v) && n < 50) begin @(negedge clk); n++; end
    chk("R9 redirect period", n, SLOW);
    chk("R9 redirect value", code_a, v + 1);
    watch_ramp("R9 redirected ramp", 230, SLOW);

    // R2: no tick, no movement
    tick = 1'b0; mode = 2'd1; tgt = 8'd200;
    repeat (20) @(negedge clk);
    chk("R2 no tick narrow", code_a, 230);
    chk("R2 no tick wide", code_b, 230);
    tick = 1'b1;
    watch_ramp("R2 fast down", 200, FAST);

    // R6: disable
    off = 1'b1; tgt = 8'd120;
    @(negedge clk);
    chk("R6 off code", code_a, 0);
    chk("R6 off code wide", code_b, 0);
    chk("R6 off enable", en_a, 1);
    chk("R6 off readback", rb_a, 0);
    mode = 2'd0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    tgt = 8'd77;
    repeat (5) @(negedge clk);
    chk("R6 off ignores target", code_a, 0);
    chk("R6 off ignores start", en_b, 1);
    tgt = 8'd120; off = 1'b0;
    @(negedge clk);
    chk("R1 load after off", code_a, 120);
    repeat (2) @(negedge clk);

    // R4 in slow mode, then slow rate resumes
    mode = 2'd2; tgt = 8'd150; start = 1'b1;
    @(negedge clk); start = 1'b0;
    watch_ramp("R4 soft start slow mode", 150, FAST);
    tgt = 8'd140;
    watch_ramp("R3 after soft start", 140, SLOW);

    summary();
    $finish;
  end
endmodule